// File: doc/BRIEF.md
# Guarded Multiply-Accumulate Unit

This block is the multiply-accumulate datapath of a 16-bit signal processor. Each multiplier operand is captured in its own input register, along with a flag that marks the operand as signed or unsigned. The full product of the two registered operands is registered one clock later. It is then sign-extended into a 36-bit accumulator format, which gives four guard bits above the 32-bit product range.

There are two accumulators. A single operation port, qualified by an enable, can clear the selected accumulator, overwrite it with the product register, add the product register to it, or subtract the product register from it. Accumulation wraps within 36 bits and never saturates internally.

On the read side, either accumulator can be viewed at full width. It can also be viewed as a 16-bit word taken from bits 31:16. That word can be rounded first, and it can be clamped to the 16-bit signed range when it does not fit. A flag reports when the clamp was applied.

Top module: `guarded_mac`

## Requirements
- R1: After reset both operand registers, both sign flags, the product register and both accumulators are zero.
- R2: `x_in`/`x_sgn` are captured only on a clock edge with `ld_x` high, and `y_in`/`y_sgn` only on an edge with `ld_y` high. `prod` shows the low 32 bits of the product of the registered operands one clock edge after they were captured. Input changes without a load do not alter `prod`.
- R3: An operand with its sign flag set is treated as two's complement, and with the flag clear it is treated as an unsigned value from 0 to 65535. The product fed to the accumulators is exact and sign-extended to 36 bits.
- R4: On an edge with `op_en` high, the accumulator chosen by `acc_sel` (0 or 1) is updated according to `op`. Code 0 clears it. Code 1 loads the sign-extended product register. Code 2 adds the product register to it. Code 3 subtracts the product register from it. The product register value used is the one held before that edge.
- R5: The unselected accumulator never changes, and with `op_en` low neither accumulator changes.
- R6: Accumulator arithmetic wraps modulo 2^36, with no saturation.
- R7: `acc_full` shows the accumulator chosen by `rd_sel` combinationally.
- R8: With `rnd_en` high, 0x8000 is added (mod 2^36) to the chosen accumulator before the 16-bit word, bits 31:16, is taken.
- R9: With `sat_en` high and bits 35 down to 31 of the (rounded) value not all equal, `sat16` is 0x7FFF for a positive value or 0x8000 for a negative value (bit 35), and `ovf` is 1. Otherwise `sat16` is bits 31:16 and `ovf` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| ld_x | input | 1 | Capture operand X and its sign flag |
| x_in | input | 16 | Operand X |
| x_sgn | input | 1 | Operand X is signed |
| ld_y | input | 1 | Capture operand Y and its sign flag |
| y_in | input | 16 | Operand Y |
| y_sgn | input | 1 | Operand Y is signed |
| op_en | input | 1 | Apply `op` this edge |
| op | input | 2 | 0 clear, 1 load, 2 add, 3 subtract |
| acc_sel | input | 1 | Accumulator that `op` targets |
| rd_sel | input | 1 | Accumulator shown on the read outputs |
| rnd_en | input | 1 | Round before taking the 16-bit word |
| sat_en | input | 1 | Clamp the 16-bit word to range |
| prod | output | 32 | Product register, low 32 bits |
| acc_full | output | 36 | Selected accumulator, full width |
| sat16 | output | 16 | Rounded and/or saturated 16-bit word |
| ovf | output | 1 | Clamp was applied |

## Verification
An operand load lands in the input register at the first edge, and the product reaches `prod` at the second edge. The bench therefore loads at one falling edge and compares `prod` two falling edges later. An accumulator operation takes effect at the single edge after it is driven, and `acc_full`, `sat16` and `ovf` follow `rd_sel`, `rnd_en` and `sat_en` without a clock. Read-side checks settle one time unit after the selects change, and they are compared against a bench-side model of both accumulators that is updated arithmetically from the swept operands.

// File: rtl/guarded_mac.sv
module guarded_mac #(
  parameter int W = 16,
  parameter int G = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ld_x,
  input  logic [W-1:0]    x_in,
  input  logic            x_sgn,
  input  logic            ld_y,
  input  logic [W-1:0]    y_in,
  input  logic            y_sgn,
  input  logic            op_en,
  input  logic [1:0]      op,
  input  logic            acc_sel,
  input  logic            rd_sel,
  input  logic            rnd_en,
  input  logic            sat_en,
  output logic [2*W-1:0]  prod,
  output logic [2*W+G-1:0] acc_full,
  output logic [W-1:0]    sat16,
  output logic            ovf
);
  localparam int PW = 2*W + 2;
  localparam int AW = 2*W + G;
  localparam int NACC = 2;

  logic [W-1:0] xr, yr;
  logic xs, ys;
  logic signed [PW-1:0] pr;
  logic [AW-1:0] acc [NACC];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      xr <= '0; xs <= 1'b0;
    end else if (ld_x) begin
      xr <= x_in; xs <= x_sgn;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      yr <= '0; ys <= 1'b0;
    end else if (ld_y) begin
      yr <= y_in; ys <= y_sgn;
    end

  wire signed [W:0] xe = {xs & xr[W-1], xr};
  wire signed [W:0] ye = {ys & yr[W-1], yr};
  wire signed [PW-1:0] pfull = xe * ye;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) pr <= '0;
    else        pr <= pfull;

  assign prod = pr[2*W-1:0];
  wire [AW-1:0] pext = {{(AW-PW){pr[PW-1]}}, pr};

  for (genvar i = 0; i < NACC; i++) begin : g_acc
    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) acc[i] <= '0;
      else if (op_en && (acc_sel == i[0]))
        case (op)
          2'd0: acc[i] <= '0;
          2'd1: acc[i] <= pext;
          2'd2: acc[i] <= acc[i] + pext;
          default: acc[i] <= acc[i] - pext;
        endcase
  end

  assign acc_full = acc[rd_sel];
  wire [AW-1:0] rv = acc_full + (rnd_en ? AW'(1) << (W-1) : AW'(0));
  wire [AW-2*W:0] top = rv[AW-1:2*W-1];
  wire oor = !((&top) || !(|top));
  assign ovf = sat_en && oor;
  assign sat16 = ovf ? (rv[AW-1] ? {1'b1, {(W-1){1'b0}}} : {1'b0, {(W-1){1'b1}}})
                     : rv[2*W-1:W];

  p_idle_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !op_en |=> ($stable(acc[0]) && $stable(acc[1])));
  p_unsel0_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (op_en && !acc_sel) |=> $stable(acc[1]));
  p_unsel1_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (op_en && acc_sel) |=> $stable(acc[0]));
  p_clear0_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (op_en && op == 2'd0 && !acc_sel) |=> (acc[0] == '0));
  p_clear1_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (op_en && op == 2'd0 && acc_sel) |=> (acc[1] == '0));
  p_prod_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!ld_x && !ld_y) |-> ##2 $stable(prod));
  p_clamp_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ovf |-> (sat16 == {1'b0, {(W-1){1'b1}}} || sat16 == {1'b1, {(W-1){1'b0}}}));
  p_no_overflow_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !sat_en |-> !ovf);
endmodule

// File: tb/guarded_mac_tb.sv
module guarded_mac_tb;
  localparam int CLK_P = 10;
  logic clk = 1'b0, rst_n = 1'b0;
  logic ld_x = 0, ld_y = 0, x_sgn = 0, y_sgn = 0, op_en = 0, acc_sel = 0, rd_sel = 0, rnd_en = 0, sat_en = 0;
  logic [15:0] x_in = 0, y_in = 0;
  logic [1:0] op = 0;
  logic [31:0] prod;
  logic [35:0] acc_full;
  logic [15:0] sat16;
  logic ovf;
  int total = 0, bad = 0;
  logic [35:0] m [2];
  logic [33:0] last_p;

  always #(CLK_P/2) clk = ~clk;

  guarded_mac u_dut (.clk(clk), .rst_n(rst_n), .ld_x(ld_x), .x_in(x_in), .x_sgn(x_sgn),
    .ld_y(ld_y), .y_in(y_in), .y_sgn(y_sgn), .op_en(op_en), .op(op), .acc_sel(acc_sel),
    .rd_sel(rd_sel), .rnd_en(rnd_en), .sat_en(sat_en), .prod(prod), .acc_full(acc_full),
    .sat16(sat16), .ovf(ovf));

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic mul(logic [15:0] a, logic as, logic [15:0] b, logic bs);
    longint pa, pb, pp;
    @(negedge clk);
    ld_x = 1; ld_y = 1; x_in = a; y_in = b; x_sgn = as; y_sgn = bs;
    @(negedge clk);
    ld_x = 0; ld_y = 0; x_in = ~a; y_in = ~b; x_sgn = ~as; y_sgn = ~bs;
    @(negedge clk);
    pa = as ? longint'($signed(a)) : longint'(a);
    pb = bs ? longint'($signed(b)) : longint'(b);
    pp = pa * pb;
    last_p = pp[33:0];
    check("R2/R3 prod", 64'(prod), 64'(pp[31:0]));
  endtask

  task automatic do_op(logic [1:0] code, logic sel);
    logic [35:0] pe;
    pe = {{2{last_p[33]}}, last_p};
    @(negedge clk);
    op_en = 1; op = code; acc_sel = sel;
    @(negedge clk);
    op_en = 0; op = 2'd0;
    case (code)
      2'd0: m[sel] = '0;
      2'd1: m[sel] = pe;
      2'd2: m[sel] = m[sel] + pe;
      default: m[sel] = m[sel] - pe;
    endcase
    rd_sel = sel; rnd_en = 0; sat_en = 0;
    #1 check("R4/R6 acc", 64'(acc_full), 64'(m[sel]));
    rd_sel = ~sel;
    #1 check("R5 other acc", 64'(acc_full), 64'(m[~sel]));
  endtask

  task automatic read_chk(logic sel, logic r, logic s);
    logic [35:0] v;
    logic o;
    logic [15:0] w;
    rd_sel = sel; rnd_en = r; sat_en = s;
    #1;
    v = m[sel] + (r ? 36'h8000 : 36'h0);
    o = s && !(v[35:31] == 5'h00 || v[35:31] == 5'h1F);
    w = o ? (v[35] ? 16'h8000 : 16'h7FFF) : v[31:16];
    check("R7 acc_full", 64'(acc_full), 64'(m[sel]));
    check("R8/R9 sat16", 64'(sat16), 64'(w));
    check("R9 ovf", 64'(ovf), 64'(o));
  endtask

  initial begin
    #(CLK_P * 200000);
    bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [15:0] vals [6];
    vals[0] = 16'h0000; vals[1] = 16'h0001; vals[2] = 16'h7FFF;
    vals[3] = 16'h8000; vals[4] = 16'hFFFF; vals[5] = 16'h1234;
    m[0] = '0; m[1] = '0; last_p = '0;
    #(CLK_P * 2 + 2);
    check("R1 prod", 64'(prod), 64'(0));
    check("R1 acc0", 64'(acc_full), 64'(0));
    rd_sel = 1; #1 check("R1 acc1", 64'(acc_full), 64'(0));
    @(negedge clk); rst_n = 1;
    for (int md = 0; md < 4; md++)
      for (int i = 0; i < 6; i++)
        for (int j = 0; j < 6; j++) begin
          mul(vals[i], md[0], vals[j], md[1]);
          do_op(2'((i + j + md) % 4), 1'((i ^ j) & 1));
          for (int k = 0; k < 4; k++) read_chk(1'(i & 1), k[0], k[1]);
        end
    // R6 wrap: repeated unsigned max products overflow 36 bits
    mul(16'hFFFF, 0, 16'hFFFF, 0);
    do_op(2'd1, 0);
    for (int k = 0; k < 10; k++) do_op(2'd2, 0);
    for (int k = 0; k < 4; k++) read_chk(0, k[0], k[1]);
    for (int k = 0; k < 12; k++) do_op(2'd3, 1);
    for (int k = 0; k < 4; k++) read_chk(1, k[0], k[1]);
    // R8 rounding carry near boundary
    mul(16'h7FFF, 1, 16'h0001, 1);
    do_op(2'd1, 0);
    mul(16'h8000, 0, 16'h0001, 0);
    for (int k = 0; k < 2; k++) do_op(2'd2, 0);
    for (int k = 0; k < 4; k++) read_chk(0, k[0], k[1]);
    // R5 op_en low: no change even with clear code
    @(negedge clk); op = 2'd0; acc_sel = 0;
    @(negedge clk); acc_sel = 1;
    @(negedge clk);
    rd_sel = 0; #1 check("R5 idle acc0", 64'(acc_full), 64'(m[0]));
    rd_sel = 1; #1 check("R5 idle acc1", 64'(acc_full), 64'(m[1]));
    // R2 no load: input change leaves prod
    @(negedge clk); x_in = 16'h5555; y_in = 16'h3333;
    @(negedge clk); @(negedge clk);
    check("R2 hold prod", 64'(prod), 64'(last_p[31:0]));
    // R4 clear
    do_op(2'd0, 0);
    do_op(2'd0, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule